// File: doc/BRIEF.md
# Sound Control Register Bank

This block is the byte-wide register file in front of a four-channel sound unit. The CPU reaches it over a simple I/O bus: an offset address, a write strobe, write data and combinational read data. It holds the per-channel control bytes, a stereo output volume byte, a channel-to-output panning byte and a master control/status byte. Every stored byte is driven out unchanged to the channel logic on a flat output bus. A separate one-cycle pulse, one per channel, tells each channel's length counter to reload.

The bank enforces the power gating of the sound unit. While the master enable bit is clear, channel, volume and panning writes overwrite the target with zero. The exception is legacy mode, where the length fields still reach the channel logic. On reads, every register ORs a fixed mask into its stored value, so bits with no storage and write-only registers read as ones. The low nibble of the master byte shows the live per-channel active inputs.

Register offsets: address = 5 × channel + slot for channels 0 to 3. The slots are: 0 sweep/wave-enable, 1 length (with duty on the square channels), 2 envelope/wave-volume, 3 frequency-low (noise polynomial on channel 3), 4 frequency-high/trigger. Slot 0 of channels 1 and 3 is unused. Offset 20 is stereo volume, 21 is panning and 22 is master control. Offsets 23 and up are outside the bank.

Top module: `snd_reg_bank`

## Requirements
- R1: After reset these bytes are stored: master 0x80 (enable set), stereo volume 0x77, panning 0xF3, channel 0 sweep 0x80, channel 0 length 0xBF, channel 0 envelope 0xF3. All other registers hold 0x00, `len_load` is 0.
- R2: With the master enable set, a write stores the full byte on the clock edge that samples `bus_wr`. It appears on `reg_flat` (byte n at bits 8n+7:8n) and on reads after that edge.
- R3: Read data is the stored byte ORed with a per-offset mask: 0→0x80, 1,6→0x3F, 2,7,17,18,20,21→0x00, 4,9,14,19→0xBF, 10→0x7F, 12→0x9F, 22→0x70.
- R4: The write-only offsets read 0xFF whatever is stored: frequency-low 3, 8, 13 and wave length 11. The noise length at 16 also reads 0xFF.
- R5: While the master enable is clear and legacy mode is off, a write to any channel, volume or panning offset stores 0x00.
- R6: In legacy mode with the enable clear, a write to a square length offset (1 or 6) stores 0x00. It still pulses that channel's `len_load` with the data ANDed with 0x3F.
- R7: In legacy mode with the enable clear, writes to the wave length (11) and noise length (16) offsets store the written byte and pulse `len_load`.
- R8: A write to offset 22 keeps only data bit 7 as the master enable (`master_on`). On reads, bits 6:4 of offset 22 are ones and bits 3:0 follow `chan_active` in the same cycle, ignoring write data.
- R9: Offsets 5, 15 and 23 to 31 read 0xFF, and writes to them change no register and raise no pulse.
- R10: `len_load` is a one-cycle pulse in the cycle after the write edge, with at most one bit set. It stays 0 for writes that are gated out, including all writes while disabled with legacy mode off.
- R11: An accepted write to a length offset pulses bit `channel` of `len_load` and loads `len_value` byte `channel`. The loaded value is the data ANDed with 0x3F, except 0xFF for the wave channel (2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| legacy_mode | input | 1 | Selects the legacy length-write exceptions |
| chan_active | input | 4 | Live per-channel active flags |
| master_on | output | 1 | Stored master enable |
| reg_flat | output | 23×8 | All stored bytes, offset n in byte n |
| len_load | output | 4 | One-cycle length reload pulse per channel |
| len_value | output | 4×8 | Last length reload value per channel |

## Verification
A write is due one edge after it is driven. The stored byte, `master_on` and the `len_load` pulse all show just after the edge that samples the strobe, and a read returns the new value from that moment on. Read data has no register, so a read is due in the same cycle its address is driven. The driver applies stimulus on the falling edge and queues one expected item per cycle. The monitor pops each item a moment after the following rising edge, so it sees write pulses and read data exactly in the cycle they are due.

// File: rtl/snd_bank_pkg.sv
// Shared constants, the register kind type and computed per-offset tables
// for the sound register bank. Assumes 8-bit registers and four channels
// of five slots each, followed by volume, panning and master bytes.
package snd_bank_pkg;
    localparam int BYTE_W       = 8;
    localparam int NUM_CH       = 4;
    localparam int SLOTS_PER_CH = 5;
    localparam int CHAN_REGS    = NUM_CH * SLOTS_PER_CH;
    localparam int IDX_VOL      = CHAN_REGS;
    localparam int IDX_PAN      = CHAN_REGS + 1;
    localparam int IDX_MASTER   = CHAN_REGS + 2;
    localparam int NUM_REGS     = CHAN_REGS + 3;
    localparam int IDX_W        = $clog2(NUM_REGS);
    localparam int CH_W         = $clog2(NUM_CH);
    localparam int SLOT_W       = $clog2(SLOTS_PER_CH);
    localparam int SLOT_LEN     = 1;
    localparam int CH_WAVE      = 2;
    localparam int CH_NOISE     = 3;
    localparam int EN_BIT       = 7;
    localparam int STATUS_W     = NUM_CH;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_CHAN,
        RK_MIX,
        RK_MASTER
    } reg_kind_e;

    // Square channel 1 and the noise channel have no slot 0.
    function automatic logic slot_exists(input int ch, input int slot);
        return !(slot == 0 && (ch == 1 || ch == CH_NOISE));
    endfunction

    // Bits that read as one regardless of storage.
    function automatic logic [BYTE_W-1:0] read_mask(input int idx);
        int ch;
        int slot;
        logic [BYTE_W-1:0] m;
        m = 8'hFF;
        if (idx == IDX_VOL || idx == IDX_PAN) begin
            m = 8'h00;
        end else if (idx == IDX_MASTER) begin
            m = 8'h70;
        end else if (idx < CHAN_REGS) begin
            ch   = idx / SLOTS_PER_CH;
            slot = idx % SLOTS_PER_CH;
            case (slot)
                0: m = (ch == 0) ? 8'h80 : ((ch == CH_WAVE) ? 8'h7F : 8'hFF);
                1: m = (ch < CH_WAVE) ? 8'h3F : 8'hFF;
                2: m = (ch == CH_WAVE) ? 8'h9F : 8'h00;
                3: m = (ch == CH_NOISE) ? 8'h00 : 8'hFF;
                default: m = 8'hBF;
            endcase
        end
        return m;
    endfunction

    // Stored value after reset.
    function automatic logic [BYTE_W-1:0] rst_value(input int idx);
        logic [BYTE_W-1:0] v;
        case (idx)
            0:          v = 8'h80;
            1:          v = 8'hBF;
            2:          v = 8'hF3;
            IDX_VOL:    v = 8'h77;
            IDX_PAN:    v = 8'hF3;
            IDX_MASTER: v = 8'h80;
            default:    v = 8'h00;
        endcase
        return v;
    endfunction

    // Bits of the length byte forwarded to the channel's counter.
    function automatic logic [BYTE_W-1:0] len_mask(input int ch);
        return (ch == CH_WAVE) ? 8'hFF : 8'h3F;
    endfunction

    // Channels whose length byte stays writable in legacy mode when disabled.
    function automatic logic legacy_open(input int ch);
        return (ch == CH_WAVE) || (ch == CH_NOISE);
    endfunction
endpackage

// File: rtl/snd_addr_decode.sv
// Address decoder: turns a bus offset into a register kind, a flat index,
// and the channel and slot of a channel register. Assumes ADDR_W is wide
// enough to reach every register and no wider than 30 bits.
module snd_addr_decode
    import snd_bank_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_kind_e         kind_o,
    output logic              in_range_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [CH_W-1:0]   ch_o,
    output logic [SLOT_W-1:0] slot_o
);
    // Classify the offset and split channel registers into channel and slot.
    always_comb begin
        int a;
        a          = int'(addr_i);
        kind_o     = RK_NONE;
        in_range_o = (a < NUM_REGS);
        idx_o      = '0;
        ch_o       = '0;
        slot_o     = '0;
        if (a < NUM_REGS) begin
            idx_o = IDX_W'(a);
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (a >= c * SLOTS_PER_CH && a < (c + 1) * SLOTS_PER_CH) begin
                ch_o   = CH_W'(c);
                slot_o = SLOT_W'(a - c * SLOTS_PER_CH);
                if (slot_exists(c, a - c * SLOTS_PER_CH)) begin
                    kind_o = RK_CHAN;
                end
            end
        end
        if (a == IDX_VOL || a == IDX_PAN) begin
            kind_o = RK_MIX;
        end
        if (a == IDX_MASTER) begin
            kind_o = RK_MASTER;
        end
    end
endmodule

// File: rtl/snd_write_gate.sv
// Write gating: decides whether a bus write stores, what byte it stores,
// and whether it raises a length reload. Purely combinational; assumes the
// kind, channel and slot come from snd_addr_decode for the same address.
module snd_write_gate
    import snd_bank_pkg::*;
(
    input  logic              wr_i,
    input  reg_kind_e         kind_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [CH_W-1:0]   ch_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              en_i,
    input  logic              legacy_i,
    output logic              st_we_o,
    output logic [IDX_W-1:0]  st_idx_o,
    output logic [BYTE_W-1:0] st_data_o,
    output logic [NUM_CH-1:0] ld_o,
    output logic [BYTE_W-1:0] ld_val_o
);
    logic is_len;
    logic open_len;

    // Length slot detection and the legacy bypass for wave and noise.
    always_comb begin
        is_len   = (kind_i == RK_CHAN) && (int'(slot_i) == SLOT_LEN);
        open_len = is_len && legacy_i && legacy_open(int'(ch_i));
    end

    // Select store enable, stored byte and length reload for this write.
    always_comb begin
        st_we_o   = 1'b0;
        st_idx_o  = idx_i;
        st_data_o = '0;
        ld_o      = '0;
        ld_val_o  = '0;
        if (wr_i) begin
            case (kind_i)
                RK_MASTER: begin
                    st_we_o           = 1'b1;
                    st_data_o[EN_BIT] = wdata_i[EN_BIT];
                end
                RK_MIX: begin
                    st_we_o   = 1'b1;
                    st_data_o = en_i ? wdata_i : '0;
                end
                RK_CHAN: begin
                    st_we_o   = 1'b1;
                    st_data_o = (en_i || open_len) ? wdata_i : '0;
                    if (is_len && (en_i || legacy_i)) begin
                        ld_o[ch_i] = 1'b1;
                        ld_val_o   = wdata_i & len_mask(int'(ch_i));
                    end
                end
                default: begin
                    st_we_o = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/snd_reg_store.sv
// Register storage: one byte per offset with computed reset values, plus
// the registered length reload pulse and per-channel reload values.
// Assumes at most one store and one reload bit per cycle.
module snd_reg_store
    import snd_bank_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [IDX_W-1:0]           widx_i,
    input  logic [BYTE_W-1:0]          wdata_i,
    input  logic [NUM_CH-1:0]          ld_i,
    input  logic [BYTE_W-1:0]          ld_val_i,
    output logic [NUM_REGS*BYTE_W-1:0] q_flat_o,
    output logic                       en_o,
    output logic [NUM_CH-1:0]          len_load_o,
    output logic [NUM_CH*BYTE_W-1:0]   len_value_o
);
    logic [BYTE_W-1:0] q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Hold one register byte, loaded when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[g] <= rst_value(g);
            end else if (we_i && widx_i == IDX_W'(g)) begin
                q[g] <= wdata_i;
            end
        end
        assign q_flat_o[g*BYTE_W +: BYTE_W] = q[g];
    end

    assign en_o = q[IDX_MASTER][EN_BIT];

    // Register the reload pulse for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_load_o <= '0;
        end else begin
            len_load_o <= ld_i;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_len
        // Keep the last reload value of one channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                len_value_o[c*BYTE_W +: BYTE_W] <= '0;
            end else if (ld_i[c]) begin
                len_value_o[c*BYTE_W +: BYTE_W] <= ld_val_i;
            end
        end
    end

    // R10
    len_pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(len_load_o));

    // R8
    master_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q[IDX_MASTER][EN_BIT-1:0] == '0);
endmodule

// File: rtl/snd_read_mux.sv
// Read path: selects the addressed byte, ORs in its fixed mask and splices
// the live channel status into the master byte. Out-of-range reads give
// all ones. Purely combinational.
module snd_read_mux
    import snd_bank_pkg::*;
(
    input  logic                       in_range_i,
    input  logic [IDX_W-1:0]           idx_i,
    input  logic [NUM_REGS*BYTE_W-1:0] q_flat_i,
    input  logic [STATUS_W-1:0]        status_i,
    output logic [BYTE_W-1:0]          rdata_o
);
    // Build the read byte from storage, mask and live status.
    always_comb begin
        rdata_o = '1;
        if (in_range_i) begin
            rdata_o = q_flat_i[int'(idx_i)*BYTE_W +: BYTE_W] | read_mask(int'(idx_i));
            if (idx_i == IDX_W'(IDX_MASTER)) begin
                rdata_o[STATUS_W-1:0] = status_i;
            end
        end
    end
endmodule

// File: rtl/snd_reg_bank.sv
// Top of the sound register bank: decode, write gating, storage and read
// mux. Writes land on the edge sampling bus_wr; reads are combinational.
// Assumes a single bus master and a synchronous active-low reset.
module snd_reg_bank
    import snd_bank_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [BYTE_W-1:0]          bus_wdata,
    output logic [BYTE_W-1:0]          bus_rdata,
    input  logic                       legacy_mode,
    input  logic [NUM_CH-1:0]          chan_active,
    output logic                       master_on,
    output logic [NUM_REGS*BYTE_W-1:0] reg_flat,
    output logic [NUM_CH-1:0]          len_load,
    output logic [NUM_CH*BYTE_W-1:0]   len_value
);
    localparam logic [ADDR_W-1:0] A_VOL    = ADDR_W'(IDX_VOL);
    localparam logic [ADDR_W-1:0] A_MASTER = ADDR_W'(IDX_MASTER);
    localparam logic [ADDR_W-1:0] A_SQ0LEN = ADDR_W'(SLOT_LEN);
    localparam logic [ADDR_W-1:0] A_LIMIT  = ADDR_W'(NUM_REGS);

    reg_kind_e         kind;
    logic              in_range;
    logic [IDX_W-1:0]  idx;
    logic [CH_W-1:0]   ch;
    logic [SLOT_W-1:0] slot;
    logic              st_we;
    logic [IDX_W-1:0]  st_idx;
    logic [BYTE_W-1:0] st_data;
    logic [NUM_CH-1:0] ld;
    logic [BYTE_W-1:0] ld_val;

    snd_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i     (bus_addr),
        .kind_o     (kind),
        .in_range_o (in_range),
        .idx_o      (idx),
        .ch_o       (ch),
        .slot_o     (slot)
    );

    snd_write_gate u_gate (
        .wr_i      (bus_wr),
        .kind_i    (kind),
        .idx_i     (idx),
        .ch_i      (ch),
        .slot_i    (slot),
        .wdata_i   (bus_wdata),
        .en_i      (master_on),
        .legacy_i  (legacy_mode),
        .st_we_o   (st_we),
        .st_idx_o  (st_idx),
        .st_data_o (st_data),
        .ld_o      (ld),
        .ld_val_o  (ld_val)
    );

    snd_reg_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (st_we),
        .widx_i      (st_idx),
        .wdata_i     (st_data),
        .ld_i        (ld),
        .ld_val_i    (ld_val),
        .q_flat_o    (reg_flat),
        .en_o        (master_on),
        .len_load_o  (len_load),
        .len_value_o (len_value)
    );

    snd_read_mux u_rmux (
        .in_range_i (in_range),
        .idx_i      (idx),
        .q_flat_i   (reg_flat),
        .status_i   (chan_active),
        .rdata_o    (bus_rdata)
    );

    // R5
    locked_mix_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !master_on && bus_addr == A_VOL)
        |=> (reg_flat[IDX_VOL*BYTE_W +: BYTE_W] == '0));

    // R6
    locked_sq_len_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !master_on && bus_addr == A_SQ0LEN)
        |=> (reg_flat[SLOT_LEN*BYTE_W +: BYTE_W] == '0));

    // R8
    master_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MASTER) |=> (master_on == $past(bus_wdata[EN_BIT])));

    // R8
    status_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_MASTER)
        |-> (bus_rdata[STATUS_W-1:0] == chan_active && bus_rdata[6:4] == 3'b111));

    // R9
    oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= A_LIMIT) |-> (bus_rdata == 8'hFF));

    // R10
    no_len_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !master_on && !legacy_mode) |=> (len_load == '0));
endmodule

// File: tb/sim_snd_reg_bank.sv
// Scoreboard bench: driver tasks queue one expected item per driven cycle,
// a monitor pops and compares them just after the next rising edge.
module sim_snd_reg_bank;
    localparam int PERIOD   = 10;
    localparam int NREG     = 23;
    localparam int NADDR    = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [4:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic         legacy_mode = 1'b0;
    logic [3:0]   chan_active = 4'b1010;
    logic         master_on;
    logic [183:0] reg_flat;
    logic [3:0]   len_load;
    logic [31:0]  len_value;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        bit         is_wr;
        int         addr;
        logic [7:0] exp_rd;
        logic [3:0] exp_ld;
        logic [7:0] exp_lv;
        string      tag;
    } item_t;
    item_t sb[$];

    logic [7:0] m_store [NREG];
    bit         m_en;

    snd_reg_bank u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .legacy_mode (legacy_mode),
        .chan_active (chan_active),
        .master_on   (master_on),
        .reg_flat    (reg_flat),
        .len_load    (len_load),
        .len_value   (len_value)
    );

    always #(PERIOD/2) clk = ~clk;

    // Requirement masks (R3, R4, R9).
    function automatic logic [7:0] mask_of(input int a);
        case (a)
            0: return 8'h80;
            1, 6: return 8'h3F;
            2, 7, 17, 18, 20, 21: return 8'h00;
            4, 9, 14, 19: return 8'hBF;
            10: return 8'h7F;
            12: return 8'h9F;
            22: return 8'h70;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input int a);
        if (a >= NREG) return 8'hFF;
        if (a == 22) return {m_en, 3'b111, chan_active};
        return m_store[a] | mask_of(a);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NREG; i++) m_store[i] = 8'h00;
        m_store[0] = 8'h80; m_store[1] = 8'hBF; m_store[2] = 8'hF3;
        m_store[20] = 8'h77; m_store[21] = 8'hF3;
        m_en = 1'b1;
    endtask

    task automatic rd(input int a, input string tag);
        item_t it;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_addr = 5'(a);
        it.is_wr = 1'b0; it.addr = a; it.exp_rd = exp_read(a);
        it.exp_ld = '0; it.exp_lv = '0; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(input int a, input logic [7:0] d, input string tag);
        item_t it;
        int ch;
        bit valid;
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = 5'(a);
        bus_wdata = d;
        it.is_wr = 1'b1; it.addr = a; it.exp_rd = '0;
        it.exp_ld = '0; it.exp_lv = '0; it.tag = tag;
        valid = (a < 22) && (a != 5) && (a != 15);
        if (a == 22) begin
            m_en = d[7];
        end else if (valid) begin
            ch = a / 5;
            if (a < 20 && (a % 5) == 1 && (m_en || legacy_mode)) begin
                it.exp_ld[ch] = 1'b1;
                it.exp_lv = d & ((ch == 2) ? 8'hFF : 8'h3F);
            end
            if (m_en || (legacy_mode && (a == 11 || a == 16))) m_store[a] = d;
            else m_store[a] = 8'h00;
        end
        sb.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Monitor: compare queued expectations just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                bit ok;
                logic [7:0] lv;
                it = sb.pop_front();
                checks++;
                lv = '0;
                for (int c = 0; c < 4; c++) if (it.exp_ld[c]) lv = len_value[c*8 +: 8];
                if (it.is_wr) ok = (len_load == it.exp_ld) && (lv == it.exp_lv);
                else ok = (bus_rdata == it.exp_rd) && (len_load == 4'b0);
                if (!ok) begin
                    errors++;
                    $display("FAIL %s addr=%0d actual rd=%h ld=%b lv=%h expected rd=%h ld=%b lv=%h",
                             it.tag, it.addr, bus_rdata, len_load, lv, it.exp_rd, it.exp_ld, it.exp_lv);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R3 R4 R9: reset contents through the read path
        for (int a = 0; a < NADDR; a++) rd(a, "R1");

        // R2 R11: enabled writes everywhere except master
        for (int a = 0; a < NADDR; a++)
            if (a != 22) wr(a, 8'(8'hC5 ^ (a * 13)), "R11");
        idle();
        for (int a = 0; a < NADDR; a++) rd(a, "R2");

        // R8: master keeps bit 7 only, status nibble is live
        wr(22, 8'h0F, "R8");
        rd(22, "R8");
        @(negedge clk);
        chan_active = 4'b0101;
        rd(22, "R8");

        // R5 R10: locked writes store zero, no reload
        for (int a = 0; a < 22; a++) wr(a, 8'hFF, "R5");
        idle();
        for (int a = 0; a < NADDR; a++) rd(a, "R5");

        // R6 R7: legacy mode while locked
        wr(22, 8'h80, "R8");
        for (int a = 0; a < 22; a++) wr(a, 8'(8'h3C ^ a), "R2");
        wr(22, 8'h7F, "R8");
        @(negedge clk);
        legacy_mode = 1'b1;
        for (int a = 0; a < 22; a++) wr(a, 8'hE7, (a == 11 || a == 16) ? "R7" : "R6");
        idle();
        for (int a = 0; a < NADDR; a++) rd(a, "R6");

        // R9: unused and out-of-range writes have no effect
        wr(5, 8'h11, "R9");
        wr(15, 8'h22, "R9");
        for (int a = 23; a < NADDR; a++) wr(a, 8'h99, "R9");
        idle();
        for (int a = 0; a < NADDR; a++) rd(a, "R9");

        idle();
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule